// File: doc/BRIEF.md
# Per-Channel Output Enable Priority Controller

This block sits beside the serial output streams of a timeslot switch. For every stream and every channel timeslot it chooses one of three pad behaviours: drive the channel data bit, drive a constant HIGH, or release the pad to high impedance. It drives no data and no pad itself. It produces two control wires per stream, `data_drive` and `pad_hiz`, which the pad logic uses to pick among the three behaviours.

Four enable sources are resolved in a fixed order. The asynchronous reset ranks highest. The output-drive pin comes next, then the run (not-standby) control bit, and last the per-channel enable bit taken from connection memory. Streams are split into groups, and each group has its own strap pin. The strap decides what a disabled output does: when the captured strap is 1 it goes to high impedance, and when it is 0 it is driven HIGH. The strap is captured only while reset is held. The drive pin and the run bit are taken into account, and the per-channel bit is latched, only on the cycle that carries the channel-start strobe. The resolved state then holds for the whole channel.

Top module: `chan_drive_arbiter`

## Requirements
- R1: While `rst_n` is low, every `data_drive` bit is 0. Each `pad_hiz` bit equals its group's strap once the strap has been held for at least 3 clocks. Group g owns output bits [g*NSTR +: NSTR].
- R2: A strap change made after reset is released has no effect. Disabled outputs keep the pad state captured during reset.
- R3: If the synchronized drive pin is 0 at a channel-start strobe, every stream is disabled for that channel. The pin must be stable for at least 3 clocks before the strobe.
- R4: If `run_bit` is 0 at a channel-start strobe, every stream is disabled for that channel.
- R5: If drive pin and run bit are both 1, the per-channel enable bit `chan_en[i]` is applied to stream i only. A 0 disables that stream and leaves the others unaffected.
- R6: A stream has `data_drive`=1 and `pad_hiz`=0 for a channel only when the drive pin, `run_bit` and its `chan_en` bit were all 1 at that channel's strobe.
- R7: Both outputs change only in the cycle after a `chan_start` strobe (or on reset). Input changes between strobes have no effect.
- R8: A disabled stream outputs `pad_hiz`=1 and `data_drive`=0 if its group mode is high impedance. If the group mode is drive-HIGH, it outputs 0 on both wires, which means drive HIGH.
- R9: Each group's mode comes only from its own strap pin.
- R10: `data_drive` and `pad_hiz` are never both 1 for the same stream.
- R11: Asserting `rst_n` clears every `data_drive` bit at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, highest-priority disable |
| drive_en_pin | input | 1 | Asynchronous output-drive enable pin, synchronized internally |
| run_bit | input | 1 | Control-register run bit; 0 means standby |
| strap_pin | input | NGRP | Per-group impedance-mode strap, captured during reset |
| chan_start | input | 1 | One-cycle strobe marking a channel boundary |
| chan_en | input | NGRP*NSTR | Per-stream channel enable from connection memory |
| data_drive | output | NGRP*NSTR | 1: pad drives channel data |
| pad_hiz | output | NGRP*NSTR | 1: pad is high impedance; both 0 means drive HIGH |

## Verification
The bench sets the two groups to opposite straps. A design that swapped group indices or shared one captured mode would then show the wrong high-impedance bits on disabled streams. It moves the straps after reset is released, which exposes a mode register that keeps tracking the pin. It also toggles enables, the drive pin and the run bit between strobes, which catches outputs that follow inputs in the middle of a channel. Finally, it asserts reset while data is being driven and checks before any clock edge, so a design whose reset acted synchronously would still show data on the pads.

// File: rtl/chan_gate_pkg.sv
package chan_gate_pkg;

  typedef enum logic [1:0] {
    PAD_HIGH = 2'd0,
    PAD_DATA = 2'd1,
    PAD_HIZ  = 2'd2
  } pad_mode_e;

  // Priority chain below reset: drive pin, then run bit, then channel bit.
  function automatic logic chan_allowed(input logic drive_pin,
                                        input logic run,
                                        input logic chan_bit);
    logic ok;
    if (!drive_pin)     ok = 1'b0;
    else if (!run)      ok = 1'b0;
    else if (!chan_bit) ok = 1'b0;
    else                ok = 1'b1;
    return ok;
  endfunction

  // Pad behaviour from resolved enable and the group's captured mode.
  function automatic pad_mode_e pad_select(input logic allow,
                                           input logic hiz_mode);
    pad_mode_e pm;
    if (allow)         pm = PAD_DATA;
    else if (hiz_mode) pm = PAD_HIZ;
    else               pm = PAD_HIGH;
    return pm;
  endfunction

endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) begin
      stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chan_gate_group.sv
module chan_gate_group
  import chan_gate_pkg::*;
#(
  parameter int NSTR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chan_start,
  input  logic            drive_s,
  input  logic            run_bit,
  input  logic            mode_hiz,
  input  logic [NSTR-1:0] ch_en,
  output logic [NSTR-1:0] drive,
  output logic [NSTR-1:0] hiz
);
  logic boundary_load;
  assign boundary_load = chan_start;

  for (genvar s = 0; s < NSTR; s++) begin : g_str
    logic      allow_q;
    pad_mode_e pm;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             allow_q <= 1'b0;
      else if (boundary_load) allow_q <= chan_allowed(drive_s, run_bit, ch_en[s]);
    end

    assign pm       = pad_select(allow_q & rst_n, mode_hiz);
    assign drive[s] = (pm == PAD_DATA);
    assign hiz[s]   = (pm == PAD_HIZ);

    AST_STABLE_MID_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(boundary_load) |-> ($stable(drive[s]) && $stable(hiz[s]))) else $error("mid-channel change"); // R7
    AST_DRIVE_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive[s]) |-> $past(boundary_load && drive_s && run_bit && ch_en[s])) else $error("drive without all enables"); // R6
  end
endmodule

// File: rtl/chan_drive_arbiter.sv
module chan_drive_arbiter #(
  parameter int NGRP        = 2,
  parameter int NSTR        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 drive_en_pin,
  input  logic                 run_bit,
  input  logic [NGRP-1:0]      strap_pin,
  input  logic                 chan_start,
  input  logic [NGRP*NSTR-1:0] chan_en,
  output logic [NGRP*NSTR-1:0] data_drive,
  output logic [NGRP*NSTR-1:0] pad_hiz
);
  localparam int NOUT = NGRP * NSTR;

  logic            drive_s;
  logic [NGRP-1:0] strap_s;
  logic [NGRP-1:0] mode_q;
  logic            in_run_q;

  cdc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_drive_sync (
    .clk(clk), .d(drive_en_pin), .q(drive_s)
  );

  cdc_sync #(.WIDTH(NGRP), .STAGES(SYNC_STAGES)) u_strap_sync (
    .clk(clk), .d(strap_pin), .q(strap_s)
  );

  // Mode tracks the strap only while reset is held, then freezes.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= strap_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_run_q <= 1'b0;
    else        in_run_q <= 1'b1;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    chan_gate_group #(.NSTR(NSTR)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_start(chan_start),
      .drive_s   (drive_s),
      .run_bit   (run_bit),
      .mode_hiz  (mode_q[g]),
      .ch_en     (chan_en[g*NSTR +: NSTR]),
      .drive     (data_drive[g*NSTR +: NSTR]),
      .hiz       (pad_hiz[g*NSTR +: NSTR])
    );
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_run_q |-> $stable(mode_q)) else $error("mode changed after reset"); // R2
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_drive & pad_hiz) == {NOUT{1'b0}}) else $error("drive and hiz both set"); // R10
endmodule

// File: tb/chan_drive_arbiter_tb.sv
`timescale 1ns/1ps
module chan_drive_arbiter_tb_top;
  localparam int NGRP = 2;
  localparam int NSTR = 16;
  localparam int NOUT = NGRP * NSTR;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            drive_en_pin = 1'b0;
  logic            run_bit = 1'b0;
  logic [NGRP-1:0] strap_pin = '0;
  logic            chan_start = 1'b0;
  logic [NOUT-1:0] chan_en = '0;
  logic [NOUT-1:0] data_drive, pad_hiz;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [NGRP-1:0] strap_cap;

  typedef struct {
    logic [NOUT-1:0] d;
    logic [NOUT-1:0] t;
    string           tag;
  } exp_t;
  exp_t sb[$];
  exp_t last_exp;

  always #2.5 clk = ~clk;

  chan_drive_arbiter #(.NGRP(NGRP), .NSTR(NSTR)) dut_i (
    .clk(clk), .rst_n(rst_n), .drive_en_pin(drive_en_pin), .run_bit(run_bit),
    .strap_pin(strap_pin), .chan_start(chan_start), .chan_en(chan_en),
    .data_drive(data_drive), .pad_hiz(pad_hiz)
  );

  function automatic logic [NOUT-1:0] disabled_hiz(input logic [NGRP-1:0] cap);
    logic [NOUT-1:0] v;
    for (int i = 0; i < NOUT; i++) v[i] = cap[i / NSTR];
    return v;
  endfunction

  function automatic exp_t model(input logic de, input logic run,
                                 input logic [NOUT-1:0] en, input string tag);
    exp_t e;
    logic [NOUT-1:0] hz;
    hz = disabled_hiz(strap_cap);
    for (int i = 0; i < NOUT; i++) begin
      e.d[i] = de && run && en[i];
      e.t[i] = e.d[i] ? 1'b0 : hz[i];
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [NOUT-1:0] act, input logic [NOUT-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare one cycle after each strobe edge.
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && chan_start) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          total++; bad++;
          $display("FAIL R7 unexpected strobe act=strobe exp=none");
        end else begin
          e = sb.pop_front();
          chk({e.tag, " drive"}, data_drive, e.d);
          chk({e.tag, " hiz"}, pad_hiz, e.t);
          chk("R10 exclusive", data_drive & pad_hiz, '0);
        end
      end
    end
  end

  task automatic do_channel(input logic de, input logic run,
                            input logic [NOUT-1:0] en, input string tag);
    @(negedge clk);
    drive_en_pin = de;
    run_bit = run;
    repeat (4) @(negedge clk);
    last_exp = model(de, run, en, tag);
    sb.push_back(last_exp);
    chan_en = en;
    chan_start = 1'b1;
    @(negedge clk);
    chan_start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 / R9: reset with group0 high impedance, group1 drive HIGH
    strap_pin = 2'b01;
    chan_en = '1;
    drive_en_pin = 1'b1;
    run_bit = 1'b1;
    repeat (5) @(negedge clk);
    chan_start = 1'b1;
    @(negedge clk);
    chan_start = 1'b0;
    @(negedge clk);
    chk("R1 reset drive", data_drive, '0);
    chk("R1 R9 reset hiz", pad_hiz, {{NSTR{1'b0}}, {NSTR{1'b1}}});
    strap_cap = 2'b01;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_channel(1'b1, 1'b1, '1, "R6 all enabled");
    do_channel(1'b1, 1'b1, 32'hA5C3_0F71, "R5 R8 per-channel");
    do_channel(1'b0, 1'b1, '1, "R3 drive pin low");
    do_channel(1'b1, 1'b0, '1, "R4 standby");

    // R7: change everything between strobes, outputs must hold
    do_channel(1'b1, 1'b1, 32'h3C96_E11B, "R7 setup");
    @(negedge clk);
    chan_en = ~chan_en;
    drive_en_pin = 1'b0;
    run_bit = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 hold drive", data_drive, last_exp.d);
    chk("R7 hold hiz", pad_hiz, last_exp.t);

    // R2: strap moves after reset, captured mode remains
    strap_pin = 2'b10;
    repeat (5) @(negedge clk);
    do_channel(1'b1, 1'b1, 32'h0FF0_F00F, "R2 strap ignored");

    // R11: asynchronous clear while driving
    do_channel(1'b1, 1'b1, '1, "R6 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async clear", data_drive, '0);
    repeat (5) @(negedge clk);
    chk("R1 R9 new strap hiz", pad_hiz, {{NSTR{1'b1}}, {NSTR{1'b0}}});
    strap_cap = 2'b10;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_channel(1'b1, 1'b1, 32'h1234_8421, "R9 swapped groups");
    do_channel(1'b1, 1'b0, 32'hFFFF_0000, "R8 disabled modes");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL R7 pending act=%0d exp=0", sb.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule